// File: doc/BRIEF.md
# Dual-Law Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A law-select input chooses between two division laws for the clock period. The power-of-two law divides by 2^(N+1) and uses only the low four bits of the divider field N. The linear law divides by 2*(N+1) and uses the whole 8-bit field. Both laws give a 50% duty cycle, so the clock level is held for a whole number of system clocks in each half period. The fastest setting divides by two.

The transfer engine drives `run` high for the length of a frame. While `run` is low the clock rests at the idle level given by `cpol`, and the block keeps loading the law, divider and polarity inputs into its working settings. Once a frame starts, those settings are frozen until `run` goes low again. The block also produces two single-cycle strobes for the shift logic. `lead_stb` marks each edge that moves the clock away from its idle level, and `trail_stb` marks each edge that returns it to idle. Each strobe is registered together with the clock level, so it is high in the first cycle of the new level.

Top module: `spi_sclk_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: After an edge with `run` low, `sclk` equals the `cpol` value sampled at that edge, and both strobes are 0.
- R3: With `law_sel` = 0 (power-of-two law), each half period of `sclk` lasts 2^E system clocks, where E is `div_val[3:0]`. Bits 7:4 of `div_val` have no effect.
- R4: With `law_sel` = 1 (linear law), each half period of `sclk` lasts N+1 system clocks, where N is the unsigned value of `div_val` (0 to 255).
- R5: If H is the half-period length, the first toggle of a frame comes after the H-th edge at which `run` is sampled high. Later toggles follow every H further run edges. The first toggle moves `sclk` away from the idle level.
- R6: `lead_stb` is 1 for exactly the one cycle in which `sclk` has just left the idle level. `trail_stb` is 1 for exactly the one cycle in which `sclk` has just returned to it. The strobes are never high at any other time.
- R7: The law, divider and polarity are captured at the last edge before a frame begins. Changes to `law_sel`, `div_val` or `cpol` while `run` stays high have no effect on `sclk` or the strobes until `run` has been low.
- R8: When `run` drops in the middle of a half period, `sclk` goes to the idle level after the next edge without a strobe. The next frame starts timing from zero.
- R9: `law_sel` = 0 with E = 0 gives the fastest clock: `sclk` toggles after every run edge, which is a ratio of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while a frame is being clocked |
| cpol | input | 1 | Idle level of the serial clock |
| law_sel | input | 1 | 0: power-of-two law, 1: linear law |
| div_val | input | DIV_W | Divider field N |
| sclk | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe on each edge that leaves the idle level |
| trail_stb | output | 1 | One-cycle strobe on each edge that returns to the idle level |

## Verification
The bench aims at the boundaries of the division laws. It uses E = 0 and N = 0, where a design with an off-by-one terminal count would stall or miss toggles, and N = 255, where a truncated counter would wrap early. It also sets the upper divider bits in power-of-two mode, which a design that does not mask them would turn into a much longer period. Frames are started with the clock idling high, so a design that leads with the wrong edge or swaps the two strobes is caught. Other cases change the divider, law and polarity in the middle of a frame, or drop `run` while the clock is high. A design that applied settings at once, or left the clock stuck high, or emitted a spurious strobe, would then differ from the cycle-by-cycle reference model.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } law_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  law_e             law_in,
  input  logic             cpol_in,
  input  logic [DIV_W-1:0] div_in,
  output law_e             law_q,
  output logic             cpol_q,
  output logic [DIV_W-1:0] div_q
);

  // Shadow copy follows the inputs while idle and freezes for a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      law_q  <= LAW_POW2;
      cpol_q <= 1'b0;
      div_q  <= '0;
    end else if (!run) begin
      law_q  <= law_in;
      cpol_q <= cpol_in;
      div_q  <= div_in;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run)) |-> ($stable(div_q) && $stable(law_q) && $stable(cpol_q))); // R7

endmodule

// File: rtl/sclk_term_calc.sv
module sclk_term_calc
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 15
) (
  input  law_e             law,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] term
);

  logic [EXP_W-1:0] exp_f;
  logic [CNT_W-1:0] pow_term;
  logic [CNT_W-1:0] lin_term;

  assign exp_f = div[EXP_W-1:0];

  // Terminal count 2^E - 1 is a thermometer mask of E ones.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign pow_term[i] = ({{(32-EXP_W){1'b0}}, exp_f} > 32'(i));
  end

  assign lin_term = CNT_W'(div);

  always_comb begin
    unique case (law)
      LAW_LINEAR: term = lin_term;
      default:    term = pow_term;
    endcase
  end

endmodule

// File: rtl/sclk_edge_core.sv
module sclk_edge_core #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol_in,
  input  logic             cpol_q,
  input  logic [CNT_W-1:0] term,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      cnt       <= '0;
      sclk      <= cpol_in;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      sclk      <= ~sclk;
      lead_stb  <= (sclk == cpol_q);
      trail_stb <= (sclk != cpol_q);
    end else begin
      cnt       <= cnt + 1'b1;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= term); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!lead_stb && !trail_stb)); // R2

  AST_LEAD_AWAY: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> (sclk != cpol_q)); // R6

  AST_TRAIL_HOME: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> (sclk == cpol_q)); // R6

  AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lead_stb |=> !lead_stb); // R6

  AST_TRAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trail_stb |=> !trail_stb); // R6

  AST_TOGGLE_HAS_STB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb)); // R5

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol,
  input  logic             law_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  localparam int CNT_W = max_int(DIV_W, (1 << EXP_W) - 1);

  law_e             law_q;
  logic             cpol_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] term;

  sclk_cfg_hold #(.DIV_W(DIV_W)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .law_in  (law_e'(law_sel)),
    .cpol_in (cpol),
    .div_in  (div_val),
    .law_q   (law_q),
    .cpol_q  (cpol_q),
    .div_q   (div_q)
  );

  sclk_term_calc #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) i_term (
    .law  (law_q),
    .div  (div_q),
    .term (term)
  );

  sclk_edge_core #(.CNT_W(CNT_W)) i_core (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cpol_in   (cpol),
    .cpol_q    (cpol_q),
    .term      (term),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic       law_sel = 1'b0;
  logic [7:0] div_val = 8'h00;
  logic       sclk, lead_stb, trail_stb;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string req = "R1";

  // Reference model state
  bit m_sclk, m_lead, m_trail;
  bit m_law, m_cpol;
  int m_div, m_cnt, m_half;

  always #2 clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .law_sel(law_sel),
    .div_val(div_val), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (rst) begin
      m_sclk = 0; m_lead = 0; m_trail = 0;
      m_law = 0; m_cpol = 0; m_div = 0; m_cnt = 0;
    end else if (!run) begin
      m_law = law_sel; m_cpol = cpol; m_div = int'(div_val);
      m_sclk = cpol; m_cnt = 0; m_lead = 0; m_trail = 0;
    end else begin
      m_half = m_law ? (m_div + 1) : (1 << (m_div % 16));
      m_cnt++;
      m_lead = 0; m_trail = 0;
      if (m_cnt == m_half) begin
        m_cnt = 0;
        m_sclk = !m_sclk;
        if (m_sclk != m_cpol) m_lead = 1; else m_trail = 1;
      end
    end
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL %s watchdog expired: actual cycles=%0d expected <=150000", req, cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if ({sclk, lead_stb, trail_stb} !== {m_sclk, m_lead, m_trail}) begin
        fails++;
        $display("FAIL %s cycle %0d: actual sclk/lead/trail=%b%b%b expected %b%b%b",
                 req, cycles, sclk, lead_stb, trail_stb, m_sclk, m_lead, m_trail);
      end
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic frame(input string r, input bit law, input bit pol,
                       input logic [7:0] dv, input int n);
    req = r;
    run = 1'b0; law_sel = law; cpol = pol; div_val = dv;
    step(2);
    run = 1'b1;
    step(n);
    run = 1'b0;
    step(2);
  endtask

  initial begin
    req = "R1"; // R1: reset state
    step(3);
    rst = 1'b0;
    req = "R2"; // R2: idle level follows polarity
    cpol = 1'b1; step(3);
    cpol = 1'b0; step(3);
    frame("R4", 1'b1, 1'b0, 8'd2, 40);       // R4 linear law, N=2
    frame("R5", 1'b1, 1'b1, 8'd3, 30);       // R5 first edge leaves high idle
    frame("R3", 1'b0, 1'b0, 8'hF3, 50);      // R3 upper bits ignored, 2^3
    frame("R9", 1'b0, 1'b0, 8'h00, 12);      // R9 ratio two
    frame("R6", 1'b1, 1'b1, 8'h00, 12);      // R6 strobes at every toggle
    // R7: change settings mid-frame
    req = "R7";
    run = 1'b0; law_sel = 1'b1; cpol = 1'b0; div_val = 8'd1;
    step(2);
    run = 1'b1; step(5);
    law_sel = 1'b0; cpol = 1'b1; div_val = 8'd7;
    step(20);
    run = 1'b0; step(3);
    // R8: drop run while sclk is away from idle
    req = "R8";
    law_sel = 1'b1; cpol = 1'b0; div_val = 8'd5;
    step(1);
    run = 1'b1; step(8);
    run = 1'b0; step(3);
    run = 1'b1; step(14);
    run = 1'b0; step(2);
    frame("R3", 1'b0, 1'b1, 8'd10, 4200);    // R3 long power-of-two period
    frame("R4", 1'b1, 1'b0, 8'd255, 1100);   // R4 largest linear divider
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule